// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block watches the clock and data lines of an I2C target and decides whether the first byte after a Start condition is meant for this device. Both lines are oversampled in the system clock domain. The block detects Start and Stop, then shifts in eight bits on the rising edges of SCL. After the eighth bit it compares the byte with three things: a programmable 7-bit own address, the general call byte (all zeros), and a promiscuous mode that accepts any byte.

When the byte matches, the block copies it into a holding register and sets a buffer-full flag. It pulls SDA low for the ninth (acknowledge) clock. On the falling edge of that ninth clock it raises a one-cycle event interrupt. A two-bit code reports which kind of match occurred, so software can tell a device-specific match from a general call. When the byte does not match, the block leaves SDA released and ignores the bus until the next Start. Software clears the full flag with a read strobe.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `rx_byte_o` is 0x00, `rx_full_o` is 0, `event_irq_o` is 0, `sda_drive_low_o` is 0 and `match_kind_o` is 0.
- R2: A byte whose upper seven bits (bit 7 first on the wire) equal `own_addr_i` is accepted with either value of bit 0, the read/write bit. It is then copied to `rx_byte_o` and `match_kind_o` becomes 1.
- R3: The byte 0x00 is accepted as a general call, with `match_kind_o` = 2, only when `gc_en_i` is 1. The byte 0x01 (zero address with read/write = 1) is never a general call.
- R4: With `promisc_en_i` = 1, every byte is accepted. A byte that matches neither the own address nor an enabled general call reports `match_kind_o` = 3.
- R5: A byte that is not accepted leaves SDA released through the ninth clock. It does not set `rx_full_o`, raises no interrupt, and leaves `rx_byte_o` unchanged.
- R6: For an accepted byte, `sda_drive_low_o` is 1 while SCL is high during the ninth clock.
- R7: `rx_full_o` and `rx_byte_o` are updated on the falling edge of the eighth SCL clock, before the ninth clock rises.
- R8: For an accepted byte, `event_irq_o` is high for exactly one system clock cycle, after the falling edge of the ninth SCL clock and not before it.
- R9: A one-cycle pulse on `rd_strobe_i` clears `rx_full_o`. `rx_byte_o` keeps its value.
- R10: A Stop (SDA rising while SCL is high) in the middle of the address returns the block to idle. SCL pulses without a new Start are then ignored.
- R11: Match codes follow a fixed priority: own address (1) first, then general call (2), then promiscuous (3).
- R12: A repeated Start in the middle of a byte restarts the bit count, and the next eight bits are taken as a fresh address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line (asynchronous) |
| sda_i | input | 1 | I2C data line as seen on the bus (asynchronous) |
| own_addr_i | input | 7 | Programmable own address |
| gc_en_i | input | 1 | Enables acceptance of the general call byte |
| promisc_en_i | input | 1 | Accepts every address byte |
| rd_strobe_i | input | 1 | Read strobe that clears the full flag |
| sda_drive_low_o | output | 1 | 1 = pull SDA low (acknowledge) |
| rx_byte_o | output | 8 | Last accepted address byte |
| rx_full_o | output | 1 | Holding register holds an unread byte |
| event_irq_o | output | 1 | One-cycle event pulse after the acknowledge clock |
| match_kind_o | output | 2 | 0 none, 1 own, 2 general call, 3 promiscuous |

## Verification
The bench sends every one of the 256 address bytes with both enables off. This separates the two own-address bytes from all others and shows that 0x00 alone is not accepted. It then sends a thinned sweep under each of the other three combinations of general call and promiscuous enables. This sweep always includes 0x00, 0x01 and the own-address pair, so the priority order and the read/write rule of the general call are resolved. Every transfer samples the flag after the eighth fall, the line during the ninth high phase and the interrupt count after the ninth fall, which together fix the edge timing. Directed sequences cover a Stop in the middle of the address followed by bare clocks, a repeated Start in the middle of a byte, and clearing by the read strobe.

// File: rtl/i2ca_pkg.sv
package i2ca_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_HOLD  = 3'd2,
    ST_ACK   = 3'd3,
    ST_WAIT  = 3'd4
  } fsm_state_t;

  typedef enum logic [1:0] {
    MK_NONE  = 2'd0,
    MK_OWN   = 2'd1,
    MK_GCALL = 2'd2,
    MK_ANY   = 2'd3
  } match_kind_t;

endpackage

// File: rtl/i2ca_rst_sync.sv
module i2ca_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/i2ca_line_sync.sv
module i2ca_line_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= RST_VAL;
        end else begin
          stage_q[s] <= d_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= RST_VAL;
        end else begin
          stage_q[s] <= stage_q[s-1];
        end
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2ca_bus_cond.sv
module i2ca_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  logic scl_p_q;
  logic sda_p_q;
  logic scl_steady_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s_i;
      sda_p_q <= sda_s_i;
    end
  end

  assign scl_steady_hi = scl_s_i & scl_p_q;
  assign start_o       = scl_steady_hi &  sda_p_q & ~sda_s_i;
  assign stop_o        = scl_steady_hi & ~sda_p_q &  sda_s_i;
  assign scl_rise_o    =  scl_s_i & ~scl_p_q;
  assign scl_fall_o    = ~scl_s_i &  scl_p_q;

endmodule

// File: rtl/i2ca_addr_cmp.sv
module i2ca_addr_cmp
  import i2ca_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              promisc_en_i,
  output match_kind_t       kind_o
);

  logic own_hit;
  logic gc_hit;

  assign own_hit = (byte_i[BYTE_W-1:1] == own_addr_i);
  assign gc_hit  = gc_en_i && (byte_i == '0);

  always_comb begin
    if (own_hit) begin
      kind_o = MK_OWN;
    end else if (gc_hit) begin
      kind_o = MK_GCALL;
    end else if (promisc_en_i) begin
      kind_o = MK_ANY;
    end else begin
      kind_o = MK_NONE;
    end
  end

endmodule

// File: rtl/i2ca_addr_fsm.sv
module i2ca_addr_fsm
  import i2ca_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_s_i,
  input  match_kind_t       kind_i,
  input  logic              rd_strobe_i,
  output logic [BYTE_W-1:0] shreg_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_full_o,
  output match_kind_t       kind_o,
  output logic              irq_o,
  output logic              ack_drive_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  fsm_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] rxb_q;
  logic              full_q, full_d;
  match_kind_t       kind_q;
  logic              irq_q, irq_d;
  logic              load;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    irq_d   = 1'b0;
    load    = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
    end else if (start_i) begin
      state_d = ST_SHIFT;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_SHIFT: begin
          if (scl_rise_i) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s_i};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              state_d = ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (scl_fall_i) begin
            if (kind_i != MK_NONE) begin
              load    = 1'b1;
              state_d = ST_ACK;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            irq_d   = 1'b1;
            state_d = ST_WAIT;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_comb begin
    if (load) begin
      full_d = 1'b1;
    end else if (rd_strobe_i) begin
      full_d = 1'b0;
    end else begin
      full_d = full_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      full_q  <= full_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb_q  <= '0;
      kind_q <= MK_NONE;
    end else if (load) begin
      rxb_q  <= sh_q;
      kind_q <= kind_i;
    end
  end

  assign shreg_o     = sh_q;
  assign rx_byte_o   = rxb_q;
  assign rx_full_o   = full_q;
  assign kind_o      = kind_q;
  assign irq_o       = irq_q;
  assign ack_drive_o = (state_q == ST_ACK);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2ca_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              promisc_en_i,
  input  logic              rd_strobe_i,
  output logic              sda_drive_low_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_full_o,
  output logic              event_irq_o,
  output logic [1:0]        match_kind_o
);

  logic              rst_n_int;
  logic [1:0]        lines_s;
  logic              start, stop, scl_rise, scl_fall;
  logic [BYTE_W-1:0] shreg;
  match_kind_t       kind_now, kind_held;

  i2ca_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  i2ca_line_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  i2ca_bus_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .scl_s_i    (lines_s[1]),
    .sda_s_i    (lines_s[0]),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  i2ca_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .byte_i       (shreg),
    .own_addr_i   (own_addr_i),
    .gc_en_i      (gc_en_i),
    .promisc_en_i (promisc_en_i),
    .kind_o       (kind_now)
  );

  i2ca_addr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_i     (start),
    .stop_i      (stop),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_s_i     (lines_s[0]),
    .kind_i      (kind_now),
    .rd_strobe_i (rd_strobe_i),
    .shreg_o     (shreg),
    .rx_byte_o   (rx_byte_o),
    .rx_full_o   (rx_full_o),
    .kind_o      (kind_held),
    .irq_o       (event_irq_o),
    .ack_drive_o (sda_drive_low_o)
  );

  assign match_kind_o = kind_held;

endmodule

// File: rtl/i2ca_checker.sv
module i2ca_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_strobe_i,
  input logic              sda_drive_low_o,
  input logic [BYTE_W-1:0] rx_byte_o,
  input logic              rx_full_o,
  input logic              event_irq_o,
  input logic [1:0]        match_kind_o
);

  // R6
  ack_has_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low_o |-> (match_kind_o != 2'd0));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_irq_o |=> !event_irq_o);

  // R8
  irq_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_irq_o |-> $past(sda_drive_low_o));

  // R7
  full_rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_o) |-> (sda_drive_low_o && match_kind_o != 2'd0));

  // R9
  strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_i |=> (!rx_full_o || sda_drive_low_o));

  // R5
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte_o) |-> sda_drive_low_o);

endmodule

bind i2c_addr_match i2ca_checker #(.BYTE_W(BYTE_W)) u_i2ca_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .rd_strobe_i     (rd_strobe_i),
  .sda_drive_low_o (sda_drive_low_o),
  .rx_byte_o       (rx_byte_o),
  .rx_full_o       (rx_full_o),
  .event_irq_o     (event_irq_o),
  .match_kind_o    (match_kind_o)
);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;

  localparam int CLK_PERIOD = 10;
  localparam int PH         = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic       clk;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_line;
  logic [6:0] own_addr;
  logic       gc_en, promisc_en, rd_strobe;
  logic       sda_drive_low;
  logic [7:0] rx_byte;
  logic       rx_full;
  logic       event_irq;
  logic [1:0] match_kind;

  int checks;
  int fails;
  int irq_total;
  bit done;

  assign sda_line = sda_m & ~sda_drive_low;

  i2c_addr_match i_i2c_addr_match (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl_m),
    .sda_i           (sda_line),
    .own_addr_i      (own_addr),
    .gc_en_i         (gc_en),
    .promisc_en_i    (promisc_en),
    .rd_strobe_i     (rd_strobe),
    .sda_drive_low_o (sda_drive_low),
    .rx_byte_o       (rx_byte),
    .rx_full_o       (rx_full),
    .event_irq_o     (event_irq),
    .match_kind_o    (match_kind)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial irq_total = 0;
  always @(negedge clk) if (event_irq === 1'b1) irq_total++;

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_ph(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_cond();
    sda_m = 1'b1; wait_ph(PH);
    scl_m = 1'b1; wait_ph(PH);
    sda_m = 1'b0; wait_ph(PH);
    scl_m = 1'b0; wait_ph(PH);
  endtask

  task automatic stop_cond();
    sda_m = 1'b0; wait_ph(PH);
    scl_m = 1'b1; wait_ph(PH);
    sda_m = 1'b1; wait_ph(PH);
  endtask

  task automatic send_bit(input logic v);
    sda_m = v;    wait_ph(PH);
    scl_m = 1'b1; wait_ph(PH);
    scl_m = 1'b0;
  endtask

  function automatic int exp_kind(input logic [7:0] b, input logic g, input logic p);
    if (b[7:1] == OWN) return 1;
    if (b == 8'h00 && g) return 2;
    if (p) return 3;
    return 0;
  endfunction

  // Sends eight bits plus the acknowledge clock and checks R2..R8, R11.
  task automatic addr_phase(input logic [7:0] b, input int kind_e,
                            inout logic [7:0] last_byte, inout int last_kind);
    int irq0;
    irq0 = irq_total;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1;
    wait_ph(PH);
    // R7: flag and byte updated after the eighth fall, ninth clock still low
    if (kind_e != 0) begin
      last_byte = b;
      last_kind = kind_e;
    end
    check($sformatf("R7/R5 full b=%02h", b), int'(rx_full), (kind_e != 0) ? 1 : 0);
    check($sformatf("R2/R3/R4 byte b=%02h", b), int'(rx_byte), int'(last_byte));
    check($sformatf("R11 kind b=%02h", b), int'(match_kind), last_kind);
    scl_m = 1'b1;
    wait_ph(PH/2);
    // R6 / R5: data line during ninth high phase
    check($sformatf("R6/R5 sda b=%02h", b), int'(sda_line), (kind_e != 0) ? 0 : 1);
    check($sformatf("R8 early irq b=%02h", b), irq_total - irq0, 0);
    wait_ph(PH/2);
    scl_m = 1'b0;
    wait_ph(PH);
    check($sformatf("R8 irq count b=%02h", b), irq_total - irq0, (kind_e != 0) ? 1 : 0);
  endtask

  task automatic strobe();
    rd_strobe = 1'b1; wait_ph(1);
    rd_strobe = 1'b0; wait_ph(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_b;
    int         last_k;
    int         irq0;
    checks = 0; fails = 0; done = 1'b0;
    last_b = 8'h00; last_k = 0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    own_addr = OWN; gc_en = 1'b0; promisc_en = 1'b0; rd_strobe = 1'b0;
    wait_ph(5);
    rst_n = 1'b1;
    wait_ph(5);

    // R1 reset state
    check("R1 rx_byte", int'(rx_byte), 0);
    check("R1 rx_full", int'(rx_full), 0);
    check("R1 irq", int'(event_irq), 0);
    check("R1 drive", int'(sda_drive_low), 0);
    check("R1 kind", int'(match_kind), 0);

    // Sweep: all bytes with enables off, thinned sweep for other modes
    for (int m = 0; m < 4; m++) begin
      gc_en      = m[0];
      promisc_en = m[1];
      for (int bi = 0; bi < 256; bi++) begin
        logic [7:0] b;
        int         k;
        b = 8'(bi);
        if (!(m == 0 || (bi % 7) == 0 || bi < 2 || b[7:1] == OWN)) continue;
        k = exp_kind(b, gc_en, promisc_en);
        start_cond();
        addr_phase(b, k, last_b, last_k);
        stop_cond();
        if (k != 0) begin
          strobe();
          // R9 strobe clears flag, byte kept
          check("R9 full cleared", int'(rx_full), 0);
          check("R9 byte kept", int'(rx_byte), int'(last_b));
        end
      end
    end

    // R10: stop in the middle of the address, then bare clocks
    gc_en = 1'b0; promisc_en = 1'b0;
    start_cond();
    for (int i = 7; i >= 4; i--) send_bit(OWN[i-1]);
    stop_cond();
    scl_m = 1'b0; wait_ph(PH);
    irq0 = irq_total;
    for (int i = 7; i >= 1; i--) send_bit(OWN[i-1]);
    send_bit(1'b0);
    sda_m = 1'b1; wait_ph(PH);
    check("R10 no full after stop", int'(rx_full), 0);
    scl_m = 1'b1; wait_ph(PH/2);
    check("R10 sda released", int'(sda_line), 1);
    wait_ph(PH/2);
    scl_m = 1'b0; wait_ph(PH);
    check("R10 no irq", irq_total - irq0, 0);
    stop_cond();

    // R12: repeated start in the middle of a byte
    start_cond();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    start_cond();
    addr_phase({OWN, 1'b1}, 1, last_b, last_k);
    check("R12 restart byte", int'(rx_byte), int'({OWN, 1'b1}));
    stop_cond();
    strobe();
    check("R9 final clear", int'(rx_full), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule